// File: doc/BRIEF.md
# Compact integer operate unit

This unit executes the register-to-register integer operations of a 16-bit compact instruction word on a 32-entry, 64-bit integer register file. Each instruction word carries a format bit, a 7-bit opcode, a 2-bit page and two 3-bit register fields. The page is shared by both operands, so each of four register groups of eight can serve as an independent stream of calculation. The opcode selects both the operation and the operand size (byte, halfword, word or long). Results narrower than a register are sign-extended, except where the operation says otherwise.

An instruction is presented with `instr_valid` for one cycle and takes effect at that clock edge. A compare updates the condition codes and writes no register. An illegal encoding, or a divide whose divisor is zero, leaves all state alone and raises a one-cycle indication. A register write port (`load_en`) fills registers from the surrounding datapath. A combinational read port shows any register.

Top module: `cou_top`

## Requirements
- R1: The destination index is {page, instr[5:3]} and the source index is {page, instr[2:0]}, where page is instr[7:6]. The opcode is instr[14:8] and instr[15] must be 0.
- R2: An instruction is illegal when any of these holds: instr[15] is 1; opcode bit 6 is 1; the cell is unused; the operation is not offered at that size. An illegal instruction sets `illegal` high in the cycle after it is accepted and changes no register and no condition code.
- R3: Opcode bits [5:4] give the size: 00 is 8 bits, 01 is 16, 10 is 32 and 11 is 64. Bit 3 selects a group and bits [2:0] a row.
  - Group 0, rows 0 to 7: swap, compare, load, store, add, subtract, multiply, divide. Multiply and divide are not offered at byte size.
  - Group 1: row 0 insert, row 2 unsigned load, row 3 XOR, row 4 AND, row 5 OR. Rows 1, 6 and 7 are unused. Insert and unsigned load are not offered at long size.
- R4: Load writes the sized source value to the destination with sign extension. Unsigned load writes it with zero fill. Insert and store replace only the low size bits of the destination and keep its upper bits.
- R5: Add, AND, OR, XOR and multiply work on the low size bits of both registers. They write the low size bits of the result, sign-extended, into the destination.
- R6: Subtract computes destination minus source at the given size and writes the sign-extended result into the source register. The destination register is left unchanged.
- R7: The condition codes are `cc` = {N, Z, V, C}, bit 3 down to bit 0. Compare sets Z when the sized operands are equal, N when the destination is below the source as signed values, and C when it is below them as unsigned values. V is always 0. Only a legal compare changes `cc`.
- R8: Swap exchanges the low size bits of the source and destination registers and keeps the upper bits of each.
- R9: Divide takes the sized source as dividend and the sized destination as divisor. It writes the quotient, truncated toward zero and sign-extended, into the destination. A quotient that does not fit wraps to the size. A zero divisor changes no register and sets `div_zero` high for the following cycle.
- R10: `load_en` writes `load_data` into register `load_idx` only in a cycle where `instr_valid` is low. A load in a cycle that carries an instruction is ignored.
- R11: After reset every register, `cc`, `illegal` and `div_zero` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 16 | Compact instruction word |
| load_en | input | 1 | Register fill request |
| load_idx | input | 5 | Register to fill |
| load_data | input | 64 | Fill value |
| rd_idx | input | 5 | Read port index |
| rd_data | output | 64 | Contents of register rd_idx |
| illegal | output | 1 | Previous instruction was illegal |
| div_zero | output | 1 | Previous instruction divided by zero |
| cc | output | 4 | Condition codes {N, Z, V, C} |

## Verification
Every effect of an instruction is due at the single rising edge that accepts it. This covers register writes, `cc`, and the `illegal` and `div_zero` pulses, which stay valid until the next edge. The bench drives an instruction on a falling edge and samples on the next falling edge. By then exactly one edge has passed, and the combinational read port reflects the updated register file without further delay. The opcode space is swept exhaustively. Randomised operands are run through every legal operation at every size, so the bench can compare against its own model of the register file after each instruction.

// File: rtl/cou_pkg.sv
package cou_pkg;

    localparam int XLEN  = 64;
    localparam int OPC_W = 7;
    localparam int CC_W  = 4;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_L = 2'd3
    } size_e;

    typedef enum logic [3:0] {
        OP_SWP, OP_CMP, OP_LDS, OP_STO, OP_ADD, OP_SUB, OP_MUL, OP_DIV,
        OP_INS, OP_LDU, OP_XOR, OP_AND, OP_IOR, OP_BAD
    } op_e;

    function automatic logic [XLEN-1:0] sext_sz(input logic [XLEN-1:0] v, input size_e sz);
        case (sz)
            SZ_B:    return {{(XLEN-8){v[7]}}, v[7:0]};
            SZ_H:    return {{(XLEN-16){v[15]}}, v[15:0]};
            SZ_W:    return {{(XLEN-32){v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] mask_sz(input size_e sz);
        case (sz)
            SZ_B:    return {{(XLEN-8){1'b0}}, {8{1'b1}}};
            SZ_H:    return {{(XLEN-16){1'b0}}, {16{1'b1}}};
            SZ_W:    return {{(XLEN-32){1'b0}}, {32{1'b1}}};
            default: return {XLEN{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/cou_decode.sv
module cou_decode
    import cou_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int FLD_W  = 3,
    localparam int IDX_W   = PAGE_W + FLD_W,
    localparam int INSTR_W = 1 + OPC_W + PAGE_W + 2 * FLD_W
) (
    input  logic [INSTR_W-1:0] instr,
    output op_e                op,
    output size_e              sz,
    output logic [IDX_W-1:0]   dst_idx,
    output logic [IDX_W-1:0]   src_idx
);

    localparam int DST_LSB = FLD_W;
    localparam int PG_LSB  = 2 * FLD_W;
    localparam int OPC_LSB = PG_LSB + PAGE_W;

    logic [OPC_W-1:0]  opc;
    logic [PAGE_W-1:0] page;
    logic [2:0]        row;

    assign opc     = instr[OPC_LSB +: OPC_W];
    assign page    = instr[PG_LSB +: PAGE_W];
    assign dst_idx = {page, instr[DST_LSB +: FLD_W]};
    assign src_idx = {page, instr[0 +: FLD_W]};
    assign sz      = size_e'(opc[5:4]);
    assign row     = opc[2:0];

    always_comb begin
        op = OP_BAD;
        if (!instr[INSTR_W-1] && !opc[6]) begin
            if (!opc[3]) begin
                case (row)
                    3'd0: op = OP_SWP;
                    3'd1: op = OP_CMP;
                    3'd2: op = OP_LDS;
                    3'd3: op = OP_STO;
                    3'd4: op = OP_ADD;
                    3'd5: op = OP_SUB;
                    3'd6: op = (sz == SZ_B) ? OP_BAD : OP_MUL;
                    default: op = (sz == SZ_B) ? OP_BAD : OP_DIV;
                endcase
            end else begin
                case (row)
                    3'd0: op = (sz == SZ_L) ? OP_BAD : OP_INS;
                    3'd2: op = (sz == SZ_L) ? OP_BAD : OP_LDU;
                    3'd3: op = OP_XOR;
                    3'd4: op = OP_AND;
                    3'd5: op = OP_IOR;
                    default: op = OP_BAD;
                endcase
            end
        end
    end

endmodule

// File: rtl/cou_alu.sv
module cou_alu
    import cou_pkg::*;
(
    input  op_e             op,
    input  size_e           sz,
    input  logic [XLEN-1:0] dv,
    input  logic [XLEN-1:0] sv,
    output logic            dst_we,
    output logic [XLEN-1:0] dst_val,
    output logic            src_we,
    output logic [XLEN-1:0] src_val,
    output logic            cc_we,
    output logic [CC_W-1:0] cc_val,
    output logic            dz
);

    logic [XLEN-1:0] msk, ds, ss, du, su;
    logic [XLEN-1:0] dvd_mag, dvs_mag, q_mag, quo;
    logic            neg_dvd, neg_dvs, lt_s, lt_u;

    assign msk = mask_sz(sz);
    assign ds  = sext_sz(dv, sz);
    assign ss  = sext_sz(sv, sz);
    assign du  = dv & msk;
    assign su  = sv & msk;

    // Divide: source is the dividend, destination the divisor (magnitude form).
    assign neg_dvd = ss[XLEN-1];
    assign neg_dvs = ds[XLEN-1];
    assign dvd_mag = neg_dvd ? (~ss + 1'b1) : ss;
    assign dvs_mag = neg_dvs ? (~ds + 1'b1) : ds;
    assign q_mag   = (dvs_mag == '0) ? '0 : (dvd_mag / dvs_mag);
    assign quo     = (neg_dvd ^ neg_dvs) ? (~q_mag + 1'b1) : q_mag;

    assign lt_s = $signed(ds) < $signed(ss);
    assign lt_u = du < su;

    always_comb begin
        dst_we  = 1'b0;
        dst_val = dv;
        src_we  = 1'b0;
        src_val = sv;
        cc_we   = 1'b0;
        cc_val  = '0;
        dz      = 1'b0;
        case (op)
            OP_SWP: begin
                dst_we  = 1'b1;
                src_we  = 1'b1;
                dst_val = (dv & ~msk) | su;
                src_val = (sv & ~msk) | du;
            end
            OP_CMP: begin
                cc_we  = 1'b1;
                cc_val = {lt_s, (du == su), 1'b0, lt_u};
            end
            OP_LDS: begin dst_we = 1'b1; dst_val = ss; end
            OP_LDU: begin dst_we = 1'b1; dst_val = su; end
            OP_STO, OP_INS: begin
                dst_we  = 1'b1;
                dst_val = (dv & ~msk) | su;
            end
            OP_ADD: begin dst_we = 1'b1; dst_val = sext_sz(dv + sv, sz); end
            OP_SUB: begin src_we = 1'b1; src_val = sext_sz(dv - sv, sz); end
            OP_MUL: begin dst_we = 1'b1; dst_val = sext_sz(dv * sv, sz); end
            OP_XOR: begin dst_we = 1'b1; dst_val = sext_sz(dv ^ sv, sz); end
            OP_AND: begin dst_we = 1'b1; dst_val = sext_sz(dv & sv, sz); end
            OP_IOR: begin dst_we = 1'b1; dst_val = sext_sz(dv | sv, sz); end
            OP_DIV: begin
                if (du == '0) begin
                    dz = 1'b1;
                end else begin
                    dst_we  = 1'b1;
                    dst_val = sext_sz(quo, sz);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cou_top.sv
module cou_top
    import cou_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int FLD_W  = 3,
    localparam int IDX_W   = PAGE_W + FLD_W,
    localparam int NREG    = 1 << IDX_W,
    localparam int INSTR_W = 1 + OPC_W + PAGE_W + 2 * FLD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               load_en,
    input  logic [IDX_W-1:0]   load_idx,
    input  logic [XLEN-1:0]    load_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [XLEN-1:0]    rd_data,
    output logic               illegal,
    output logic               div_zero,
    output logic [CC_W-1:0]    cc
);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
        logic [CC_W-1:0]           cc;
        logic                      illegal;
        logic                      dz;
    } state_t;

    state_t st_d, st_q;

    op_e             op;
    size_e           sz;
    logic [IDX_W-1:0] d_idx, s_idx;
    logic            dst_we, src_we, cc_we, dz;
    logic [XLEN-1:0] dst_val, src_val;
    logic [CC_W-1:0] cc_val;

    cou_decode #(.PAGE_W(PAGE_W), .FLD_W(FLD_W)) u_dec (
        .instr   (instr),
        .op      (op),
        .sz      (sz),
        .dst_idx (d_idx),
        .src_idx (s_idx)
    );

    cou_alu u_alu (
        .op      (op),
        .sz      (sz),
        .dv      (st_q.regs[d_idx]),
        .sv      (st_q.regs[s_idx]),
        .dst_we  (dst_we),
        .dst_val (dst_val),
        .src_we  (src_we),
        .src_val (src_val),
        .cc_we   (cc_we),
        .cc_val  (cc_val),
        .dz      (dz)
    );

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        st_d.dz      = 1'b0;
        if (instr_valid) begin
            if (op == OP_BAD) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.dz = dz;
                if (src_we) st_d.regs[s_idx] = src_val;
                if (dst_we) st_d.regs[d_idx] = dst_val;
                if (cc_we)  st_d.cc = cc_val;
            end
        end else if (load_en) begin
            st_d.regs[load_idx] = load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.regs[rd_idx];
    assign illegal  = st_q.illegal;
    assign div_zero = st_q.dz;
    assign cc       = st_q.cc;

endmodule

// File: rtl/cou_checker.sv
module cou_checker
    import cou_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int INSTR_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      instr_valid,
    input logic [INSTR_W-1:0]        instr,
    input logic                      illegal,
    input logic                      div_zero,
    input logic [CC_W-1:0]           cc,
    input logic [NREG-1:0][XLEN-1:0] regs
);

    logic [OPC_W-1:0] opc;
    logic             is_cmp;
    assign opc    = instr[INSTR_W-2 -: OPC_W];
    assign is_cmp = !instr[INSTR_W-1] && !opc[6] && !opc[3] && (opc[2:0] == 3'd1);

    p_illegal_keeps_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(regs) && $stable(cc)));

    p_illegal_needs_instr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(instr_valid));

    p_pulses_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal && div_zero));

    p_divzero_keeps_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> $stable(regs));

    p_cc_only_on_compare_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cc) |-> $past(instr_valid && is_cmp));

    p_cc_equal_excludes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cc[2] |-> (!cc[3] && !cc[1] && !cc[0]));

endmodule

bind cou_top cou_checker #(.NREG(NREG), .INSTR_W(INSTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .illegal     (illegal),
    .div_zero    (div_zero),
    .cc          (cc),
    .regs        (st_q.regs)
);

// File: tb/tb_cou_top.sv
module tb_cou_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        load_en = 1'b0;
    logic [4:0]  load_idx = '0;
    logic [63:0] load_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        illegal, div_zero;
    logic [3:0]  cc;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] mdl [32];
    logic [3:0]  mdl_cc;
    logic        exp_ill, exp_dz;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    cou_top dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .illegal(illegal), .div_zero(div_zero), .cc(cc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] next_rand(input logic [63:0] x);
        logic [63:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    function automatic logic [63:0] sx(input logic [63:0] v, input int sz);
        case (sz)
            0: return 64'(longint'(byte'(v[7:0])));
            1: return 64'(longint'(shortint'(v[15:0])));
            2: return 64'(longint'(int'(v[31:0])));
            default: return v;
        endcase
    endfunction

    function automatic logic [63:0] msk(input int sz);
        return (sz == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sz)) - 64'd1);
    endfunction

    // Legality per R2/R3: kind 0..12 or -1.
    function automatic int kind_of(input logic [7:0] top);
        int sz = int'(top[5:4]);
        int row = int'(top[2:0]);
        if (top[7] || top[6]) return -1;
        if (!top[3]) begin
            if (row >= 6 && sz == 0) return -1;
            return row;
        end
        case (row)
            0: return (sz == 3) ? -1 : 8;
            2: return (sz == 3) ? -1 : 9;
            3: return 10;
            4: return 11;
            5: return 12;
            default: return -1;
        endcase
    endfunction

    task automatic model(input logic [15:0] w);
        int k = kind_of(w[15:8]);
        int sz = int'(w[13:12]);
        int d = {w[7:6], w[5:3]};
        int s = {w[7:6], w[2:0]};
        logic [63:0] dv = mdl[d], sv = mdl[s], m = msk(sz);
        longint a, b, q;
        exp_ill = (k < 0);
        exp_dz = 1'b0;
        case (k)
            0: begin mdl[d] = (dv & ~m) | (sv & m); mdl[s] = (sv & ~m) | (dv & m); end
            1: begin
                a = longint'(sx(dv, sz)); b = longint'(sx(sv, sz));
                mdl_cc = {(a < b), ((dv & m) == (sv & m)), 1'b0, ((dv & m) < (sv & m))};
            end
            2: mdl[d] = sx(sv, sz);
            3, 8: mdl[d] = (dv & ~m) | (sv & m);
            4: mdl[d] = sx(dv + sv, sz);
            5: mdl[s] = sx(dv - sv, sz);
            6: mdl[d] = sx(64'(longint'(sx(dv, sz)) * longint'(sx(sv, sz))), sz);
            7: begin
                a = longint'(sx(sv, sz)); b = longint'(sx(dv, sz));
                if (b == 0) exp_dz = 1'b1;
                else begin
                    q = (b == -1) ? -a : a / b;
                    mdl[d] = sx(64'(q), sz);
                end
            end
            9: mdl[d] = sv & m;
            10: mdl[d] = sx(dv ^ sv, sz);
            11: mdl[d] = sx(dv & sv, sz);
            12: mdl[d] = sx(dv | sv, sz);
            default: ;
        endcase
    endtask

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input int idx);
        rd_idx = 5'(idx);
        #1;
        check64(req, rd_data, mdl[idx]);
    endtask

    task automatic load(input int idx, input logic [63:0] v);
        @(negedge clk);
        load_en = 1'b1; load_idx = 5'(idx); load_data = v;
        @(negedge clk);
        load_en = 1'b0;
        mdl[idx] = v;
    endtask

    task automatic exec(input logic [15:0] w, input string req, input bit full);
        int d = {w[7:6], w[5:3]};
        int s = {w[7:6], w[2:0]};
        model(w);
        @(negedge clk);
        instr_valid = 1'b1; instr = w;
        @(negedge clk);
        instr_valid = 1'b0;
        check64({req, " R2 illegal"}, 64'(illegal), 64'(exp_ill));
        check64({req, " R9 div_zero"}, 64'(div_zero), 64'(exp_dz));
        check64({req, " R7 cc"}, 64'(cc), 64'(mdl_cc));
        if (full) begin
            for (int i = 0; i < 32; i++) chk_reg(req, i);
        end else begin
            chk_reg({req, " R1 dst"}, d);
            chk_reg({req, " R1 src"}, s);
        end
    endtask

    function automatic logic [15:0] mk(input int sz, input int grp, input int row,
                                       input int pg, input int d, input int s);
        return {1'b0, 1'b0, 2'(sz), 1'(grp), 3'(row), 2'(pg), 3'(d), 3'(s)};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        string tag;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        mdl_cc = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check64("R11 illegal", 64'(illegal), 0);
        check64("R11 div_zero", 64'(div_zero), 0);
        check64("R11 cc", 64'(cc), 0);
        for (int i = 0; i < 32; i++) chk_reg("R11 reg", i);
        rst_n = 1'b1;
        @(negedge clk);

        // R3..R9 sweep: all sizes, all legal cells, random operands and pages (R1)
        for (int sz = 0; sz < 4; sz++) begin
            for (int grp = 0; grp < 2; grp++) begin
                for (int row = 0; row < 8; row++) begin
                    if (kind_of({2'b00, 2'(sz), 1'(grp), 3'(row)}) < 0) continue;
                    for (int t = 0; t < 8; t++) begin
                        int pg, d, s;
                        logic [63:0] vd, vs;
                        rng = next_rand(rng); pg = int'(rng[1:0]); d = int'(rng[4:2]); s = int'(rng[7:5]);
                        if (t == 0) s = d;
                        rng = next_rand(rng); vd = rng;
                        rng = next_rand(rng); vs = rng;
                        if (t == 1) vd = '0;                  // R9 zero divisor
                        if (t == 2) vs = vd;                  // R7 equal compare
                        if (t == 3) begin vd = 64'hFFFF_FFFF_FFFF_FFFF; vs = msk(sz) ^ (msk(sz) >> 1); end
                        if (t == 4) begin vd = ~64'd0; vs = 64'd1; end
                        load(pg * 8 + d, vd);
                        if (s != d) load(pg * 8 + s, vs);
                        $sformat(tag, "R4 R5 R6 R8 sz%0d g%0d r%0d", sz, grp, row);
                        exec(mk(sz, grp, row, pg, d, s), tag, 1'b0);
                    end
                end
            end
        end

        // R2/R3: exhaustive over format bit and opcode; illegal ones checked on every register
        for (int i = 0; i < 32; i++) begin
            rng = next_rand(rng); load(i, rng);
        end
        for (int op = 0; op < 256; op++) begin
            logic [15:0] w;
            rng = next_rand(rng);
            w = {8'(op), rng[7:0]};
            if (kind_of(8'(op)) == 7 && rng[0]) begin
                load({w[7:6], w[5:3]}, 64'(rng[15:8]) + 64'd3);
            end
            exec(w, "R2 R3 opcode sweep", kind_of(8'(op)) < 0);
        end

        // R10: load ignored while an instruction is accepted
        load(20, 64'h1234_5678_9ABC_DEF0);
        load(9, 64'h1);
        load(10, 64'h2);
        model(mk(3, 0, 4, 1, 1, 2));   // add long, r9 += r10
        @(negedge clk);
        instr_valid = 1'b1; instr = mk(3, 0, 4, 1, 1, 2);
        load_en = 1'b1; load_idx = 5'd20; load_data = 64'hDEAD;
        @(negedge clk);
        instr_valid = 1'b0; load_en = 1'b0;
        chk_reg("R10 load ignored", 20);
        chk_reg("R10 instr done", 9);

        // R4 specific: byte load sign extension vs unsigned load vs insert
        load(0, 64'hAAAA_AAAA_AAAA_AAAA);
        load(1, 64'h0000_0000_0000_0080);
        exec(mk(0, 0, 2, 0, 0, 1), "R4 sign-extend load", 1'b0);
        check64("R4 sext value", mdl[0], 64'hFFFF_FFFF_FFFF_FF80);
        load(0, 64'hAAAA_AAAA_AAAA_AAAA);
        exec(mk(0, 1, 0, 0, 0, 1), "R4 insert", 1'b0);
        chk_reg("R4 insert upper kept", 0);
        exec(mk(1, 1, 2, 0, 0, 1), "R4 unsigned load", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule